// File: doc/BRIEF.md
# Masked Auxiliary Control Overlay

This block sits on the transmit path of a serial radio link, where it places bits supplied by the application into the outgoing stream of frame words. On every link clock it receives three 32-bit inputs: the word that the internal frame builder produced, a word of auxiliary data, and a per-bit mask. Where a mask bit is 1, the output takes the auxiliary bit. Where it is 0, the output keeps the internally built bit. The auxiliary bits are copied exactly as they arrive. The block calculates no checksum and changes nothing else.

One word position is protected: the first word of basic frame zero of hyperframe zero, which carries the K28.5 comma character. The frame timing generator supplies the word index, the basic-frame index and the hyperframe index as inputs. If any mask bit is set while those three indices are all zero, the block raises a one-cycle error pulse on the next clock. The merged word comes out of a register, so it also appears one cycle after its inputs.

Top module: `aux_overlay_top`

## Requirements
- R1: For each bit i, when mask[i]=1 the output word bit i, one clock after the inputs, equals the auxiliary data bit i.
- R2: For each bit i, when mask[i]=0 the output word bit i, one clock after the inputs, equals the internal word bit i.
- R3: The output word carries no added checksum or other field. With a mask of all ones, the output equals the auxiliary word exactly, one clock later.
- R4: The protected comma position is the cycle in which the word index, the basic-frame index and the hyperframe index are all zero. At no other combination of indices does the error output assert.
- R5: If any mask bit is 1 at the comma position, the error output is 1 in the following cycle.
- R6: The error output is a pulse for each offending word. It is 0 one cycle after any input cycle that was not an offending word, so it does not latch.
- R7: The error depends only on the mask and the indices. At the comma position with the mask all zero, the error stays 0 whatever the auxiliary data.
- R8: Synchronous active-high reset clears the output word to 0 and the error to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| int_word | input | 32 | Internally built frame word |
| aux_word | input | 32 | Auxiliary data word |
| aux_mask | input | 32 | Per-bit select; 1 selects the auxiliary bit |
| word_idx | input | 8 | Index of the word within the basic frame |
| bf_idx | input | 8 | Index of the basic frame within the hyperframe |
| hf_idx | input | 8 | Hyperframe index |
| out_word | output | 32 | Merged word, registered |
| comma_err | output | 1 | One-cycle pulse: the mask touched the comma word |

## Verification
The hardest cases to reach are near misses of the comma position, where exactly one of the three indices is non-zero and the mask is non-zero. They must produce no error, even though they differ from the protected position by a single index. The stimulus steps through each single-index near miss with a full mask. It also places offending words back to back, so that the pulse behaviour is observed when it is followed by a clean word. Finally, it puts a zero mask with arbitrary auxiliary data at the comma position, to show that the auxiliary data alone never raises the error.

// File: rtl/aux_overlay_pkg.sv
package aux_overlay_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        idx_t word_idx;
        idx_t bf_idx;
        idx_t hf_idx;
    } frame_pos_t;

    function automatic logic pos_is_comma(input frame_pos_t p);
        return (p.word_idx == '0) && (p.bf_idx == '0) && (p.hf_idx == '0);
    endfunction
endpackage

// File: rtl/aux_bit_merge.sv
module aux_bit_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] ovr_i,
    input  logic [W-1:0] sel_i,
    output logic [W-1:0] merged_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged_o[b] = sel_i[b] ? ovr_i[b] : base_i[b];
    end
endmodule

// File: rtl/comma_guard.sv
module comma_guard
    import aux_overlay_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  frame_pos_t   pos_i,
    input  logic [W-1:0] mask_i,
    output logic         violate_o
);
    always_comb violate_o = pos_is_comma(pos_i) && (|mask_i);
endmodule

// File: rtl/aux_overlay_top.sv
module aux_overlay_top
    import aux_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] int_word,
    input  logic [WORD_W-1:0] aux_word,
    input  logic [WORD_W-1:0] aux_mask,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [IDX_W-1:0]  bf_idx,
    input  logic [IDX_W-1:0]  hf_idx,
    output logic [WORD_W-1:0] out_word,
    output logic              comma_err
);
    frame_pos_t pos;
    word_t      merged;
    logic       violate;

    assign pos = '{word_idx: word_idx, bf_idx: bf_idx, hf_idx: hf_idx};

    aux_bit_merge #(.W(WORD_W)) u_merge (
        .base_i  (int_word),
        .ovr_i   (aux_word),
        .sel_i   (aux_mask),
        .merged_o(merged)
    );

    comma_guard #(.W(WORD_W)) u_guard (
        .pos_i    (pos),
        .mask_i   (aux_mask),
        .violate_o(violate)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            comma_err <= 1'b0;
        end else begin
            out_word  <= merged;
            comma_err <= violate;
        end
    end
endmodule

// File: rtl/aux_overlay_chk.sv
module aux_overlay_chk
    import aux_overlay_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] int_word,
    input logic [WORD_W-1:0] aux_word,
    input logic [WORD_W-1:0] aux_mask,
    input logic [IDX_W-1:0]  word_idx,
    input logic [IDX_W-1:0]  bf_idx,
    input logic [IDX_W-1:0]  hf_idx,
    input logic [WORD_W-1:0] out_word,
    input logic              comma_err
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    // R1
    p_masked_bits_r1: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((out_word & $past(aux_mask)) == ($past(aux_word) & $past(aux_mask))));
    // R2
    p_kept_bits_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((out_word & ~$past(aux_mask)) == ($past(int_word) & ~$past(aux_mask))));
    // R4
    p_no_err_off_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (word_idx != 0 || bf_idx != 0 || hf_idx != 0) |=> !comma_err);
    // R5
    p_err_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (word_idx == 0 && bf_idx == 0 && hf_idx == 0 && aux_mask != 0) |=> comma_err);
    // R7
    p_no_err_zero_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (aux_mask == 0) |=> !comma_err);
    // R8
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (out_word == 0 && !comma_err));
endmodule

bind aux_overlay_top aux_overlay_chk u_chk (.*);

// File: tb/aux_overlay_top_tb_top.sv
module aux_overlay_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic [31:0] int_word, aux_word, aux_mask, out_word;
    logic [7:0]  word_idx, bf_idx, hf_idx;
    logic        comma_err;

    typedef struct {
        logic [31:0] w;
        logic        e;
        string       req;
    } exp_t;
    exp_t q[$];

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_overlay_top dut_i (.*);

    task automatic drive(input logic [31:0] iw, aw, m,
                         input logic [7:0] wi, bi, hi, input string req);
        exp_t e;
        @(posedge clk); #1;
        int_word = iw; aux_word = aw; aux_mask = m;
        word_idx = wi; bf_idx = bi; hf_idx = hi;
        e.w = (aw & m) | (iw & ~m);
        e.e = (wi == 0 && bi == 0 && hi == 0 && m != 0);
        e.req = req;
        q.push_back(e);
    endtask

    // monitor: sample at negedge; item pushed after edge k appears after edge k+1
    initial begin
        @(negedge clk);
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0 && dut_i.clk === 1'b0) begin
            end
        end
    end

    int lag = 0;
    always @(negedge clk) begin
        if (rst) lag <= 0;
        else if (q.size() > 0) begin
            if (lag == 0) lag <= 1;
            else begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (out_word !== e.w || comma_err !== e.e) begin
                    n_fail++;
                    $display("FAIL %s: word=%h err=%b expected word=%h err=%b",
                             e.req, out_word, comma_err, e.w, e.e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; int_word = 32'hFFFF_FFFF; aux_word = 32'hFFFF_FFFF; aux_mask = '1;
        word_idx = 0; bf_idx = 0; hf_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_word !== 0 || comma_err !== 0) begin
            n_fail++;
            $display("FAIL R8: word=%h err=%b expected word=0 err=0", out_word, comma_err);
        end
        @(posedge clk); #1; rst = 0;
        aux_mask = 0; word_idx = 1;
        q.delete();
        // R1/R2 patterns
        drive(32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000, 3, 1, 0, "R2");
        drive(32'h1234_5678, 32'hDEAD_BEEF, 32'hFFFF_0000, 3, 1, 0, "R1");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 32'h0F0F_0F0F, 7, 2, 4, "R1");
        drive(32'hCAFE_F00D, 32'h0BAD_C0DE, 32'h8000_0001, 1, 0, 0, "R2");
        // R3 full mask passthrough
        drive(32'h0000_0000, 32'h1357_9BDF, 32'hFFFF_FFFF, 2, 0, 0, "R3");
        // R5 and R6: back-to-back offenders then clean word
        drive(32'hBC00_0000, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, "R5");
        drive(32'hBC00_0000, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0, "R5");
        drive(32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1, 0, 0, "R6");
        drive(32'hBC00_0000, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        drive(32'h0000_0002, 32'h0, 32'hFFFF_FFFF, 0, 0, 1, "R6");
        // R4 near misses
        drive(32'h1, 32'h2, 32'hFFFF_FFFF, 1, 0, 0, "R4");
        drive(32'h1, 32'h2, 32'hFFFF_FFFF, 0, 1, 0, "R4");
        drive(32'h1, 32'h2, 32'hFFFF_FFFF, 0, 0, 1, "R4");
        drive(32'h1, 32'h2, 32'hFFFF_FFFF, 0, 128, 0, "R4");
        // R7 zero mask, arbitrary aux at comma
        drive(32'hBC00_0000, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, "R7");
        drive(32'hBC00_0000, 32'h1234_5678, 32'h0, 0, 0, 0, "R7");
        drive(32'h0, 32'h0, 32'h0, 9, 9, 9, "R6");
        repeat (4) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule